// File: doc/BRIEF.md
# Paged Word-Address Counter and Write Buffer

This block keeps the internal byte address of a 8192-byte memory arranged as 256 pages of 32 bytes, and collects page-write bytes before they reach the storage. A controller in front of it turns serial traffic into single-cycle commands: load a new address, push one write byte, step one read byte forward, or commit the collected bytes. The storage itself sits outside the block as a register array with a combinational read port. The block drives that array's read address (the current address) and, on a commit, one page row with a write enable per byte slot.

Address stepping depends on the direction. A written byte advances only the five offset bits, so a long write stays inside its page and wraps to slot 0. A read step advances all thirteen bits, so a long read walks off the end of memory and continues from address 0. The counter holds its value between commands, so a read issued without a fresh load continues from the byte after the last one touched. Each buffer slot has its own valid flag, so a commit touches only the bytes that were written. A write-protect input, sampled on the commit cycle, blocks every commit aimed at the top quarter of memory.

Top module: `eep_waddr_pbuf`

## Requirements
- R1: After a synchronous reset, `cur_addr` is 0, `rd_data` is 0, `arr_we` is all zero and the buffer holds no written byte.
- R2: A load command sets `cur_addr` to `ld_addr` on the next cycle and discards every uncommitted byte. In that cycle the write and read strobes are ignored.
- R3: An accepted write byte is stored in slot `cur_addr[4:0]`. On the next cycle `cur_addr[4:0]` has advanced by one modulo 32, and `cur_addr[12:5]` is unchanged.
- R4: When more than 32 bytes are written without a commit, a later byte replaces the earlier byte of the same slot, and only the latest value is committed.
- R5: An accepted read step (read strobe with no load or write strobe) loads `rd_data` with `arr_rdata` as seen at the current address and advances `cur_addr` by one over the full 13 bits, so 0x1FFF is followed by 0x0000. It also discards uncommitted bytes.
- R6: With no load, write or read strobe, `cur_addr` keeps its value, including across a commit. A later read therefore continues from the last address touched plus one.
- R7: In the cycle `commit` is high, `arr_we[i]` is 1 exactly for each slot i written since the last load, read step or commit. `arr_wdata[8*i+7:8*i]` carries slot i, and `arr_page` equals `cur_addr[12:5]`. The buffer is empty afterwards.
- R8: A write byte accepted in the same cycle as `commit` is part of that commit, and it does not stay in the buffer afterwards.
- R9: If `wp` is 1 in the commit cycle and `cur_addr` lies in 0x1800..0x1FFF, `arr_we` stays all zero and the buffered bytes are dropped. Commits to lower addresses, or with `wp` at 0, proceed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load-address command |
| ld_addr | input | 13 | Address to load |
| wr_en | input | 1 | Write-byte strobe |
| wr_data | input | 8 | Byte to buffer |
| rd_en | input | 1 | Read-advance strobe |
| commit | input | 1 | Commit buffered bytes to the array |
| wp | input | 1 | Write protect for the top quarter |
| arr_rdata | input | 8 | Array byte at `cur_addr` |
| cur_addr | output | 13 | Current word address, also the array read address |
| rd_data | output | 8 | Last byte captured by a read step |
| arr_we | output | 32 | Per-slot write enables for the committed page |
| arr_page | output | 8 | Page row being written |
| arr_wdata | output | 256 | Page data, slot i in bits 8i+7:8i |

## Verification
Two functions can land in the same cycle: a write byte can arrive together with a commit, and a command strobe can collide with another strobe (load with write, write with read). The bench drives these pairs on purpose, both as directed cases and through a random mix with commit and write protect toggling. It predicts the enable mask, the page data and the next address from a behavioural model with its own memory copy. Read-back through `rd_data` then shows whether the byte that arrived with the commit landed in storage and whether the ignored strobe left any trace.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam int EEP_ADDR_W = 13;
    localparam int EEP_OFF_W  = 5;
    localparam int EEP_DATA_W = 8;
    localparam int EEP_PROT_W = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } eep_op_e;

    // load beats write, write beats read
    function automatic eep_op_e pick_op(input logic ld, input logic wr, input logic rd);
        if (ld)      return OP_LOAD;
        else if (wr) return OP_WRITE;
        else if (rd) return OP_READ;
        else         return OP_IDLE;
    endfunction

endpackage

// File: rtl/eep_addr_ctr.sv
module eep_addr_ctr
    import eep_pkg::*;
#(
    parameter int ADDR_W = EEP_ADDR_W,
    parameter int OFF_W  = EEP_OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  eep_op_e           op,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic [ADDR_W-1:0] addr_q
);
    localparam int PAGE_W = ADDR_W - OFF_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else begin
            case (op)
                OP_LOAD:  addr_q <= ld_addr;
                OP_WRITE: addr_q <= {addr_q[ADDR_W-1:OFF_W], addr_q[OFF_W-1:0] + OFF_W'(1)};
                OP_READ:  addr_q <= addr_q + ADDR_W'(1);
                default:  addr_q <= addr_q;
            endcase
        end
    end

    a_r2_load_takes: assert property (@(posedge clk) disable iff (rst)
        op == OP_LOAD |=> addr_q == $past(ld_addr));

    a_r3_page_kept: assert property (@(posedge clk) disable iff (rst)
        op == OP_WRITE |=> (addr_q[ADDR_W-1:OFF_W] == $past(addr_q[ADDR_W-1:OFF_W]))
                         && (addr_q[OFF_W-1:0] == OFF_W'($past(addr_q[OFF_W-1:0]) + 1'b1)));

    a_r5_read_step: assert property (@(posedge clk) disable iff (rst)
        op == OP_READ |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        op == OP_IDLE |=> $stable(addr_q));

    logic unused_pw;
    assign unused_pw = (PAGE_W > 0);

endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf
    import eep_pkg::*;
#(
    parameter int OFF_W  = EEP_OFF_W,
    parameter int DATA_W = EEP_DATA_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  eep_op_e                       op,
    input  logic [OFF_W-1:0]              off,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          commit,
    output logic [(1<<OFF_W)-1:0]         eff_valid,
    output logic [(1<<OFF_W)*DATA_W-1:0]  eff_data
);
    localparam int SLOTS = 1 << OFF_W;

    logic [SLOTS-1:0] held;
    logic             flush;

    assign flush = commit || (op == OP_LOAD) || (op == OP_READ);

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic              v_q;
        logic [DATA_W-1:0] d_q;
        logic              hit;

        assign hit = (op == OP_WRITE) && (off == OFF_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                d_q <= '0;
            end else begin
                if (flush)    v_q <= 1'b0;
                else if (hit) v_q <= 1'b1;
                if (hit)      d_q <= wr_data;
            end
        end

        assign held[i]                       = v_q;
        assign eff_valid[i]                  = v_q | hit;
        assign eff_data[i*DATA_W +: DATA_W]  = hit ? wr_data : d_q;
    end

    a_r7_empty_after_commit: assert property (@(posedge clk) disable iff (rst)
        commit |=> held == '0);

    a_r2_empty_after_load: assert property (@(posedge clk) disable iff (rst)
        op == OP_LOAD |=> held == '0);

    a_r3_one_new_slot: assert property (@(posedge clk) disable iff (rst)
        (op == OP_WRITE && !commit) |=> $countones(held & ~$past(held)) <= 1);

endmodule

// File: rtl/eep_commit_gate.sv
module eep_commit_gate
    import eep_pkg::*;
#(
    parameter int ADDR_W = EEP_ADDR_W,
    parameter int OFF_W  = EEP_OFF_W,
    parameter int DATA_W = EEP_DATA_W,
    parameter int PROT_W = EEP_PROT_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          commit,
    input  logic                          wp,
    input  logic [ADDR_W-OFF_W-1:0]       page,
    input  logic [(1<<OFF_W)-1:0]         eff_valid,
    input  logic [(1<<OFF_W)*DATA_W-1:0]  eff_data,
    output logic [(1<<OFF_W)-1:0]         arr_we,
    output logic [ADDR_W-OFF_W-1:0]       arr_page,
    output logic [(1<<OFF_W)*DATA_W-1:0]  arr_wdata
);
    localparam int PAGE_W = ADDR_W - OFF_W;

    logic in_top;
    logic blocked;

    assign in_top    = &page[PAGE_W-1 -: PROT_W];
    assign blocked   = wp && in_top;
    assign arr_we    = (commit && !blocked) ? eff_valid : '0;
    assign arr_page  = page;
    assign arr_wdata = eff_data;

    a_r7_we_subset: assert property (@(posedge clk) disable iff (rst)
        (arr_we & ~eff_valid) == '0);

    a_r9_top_locked: assert property (@(posedge clk) disable iff (rst)
        (wp && page >= PAGE_W'(((1 << PROT_W) - 1) << (PAGE_W - PROT_W))) |-> arr_we == '0);

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !commit |-> arr_we == '0);

endmodule

// File: rtl/eep_waddr_pbuf.sv
module eep_waddr_pbuf
    import eep_pkg::*;
#(
    parameter int ADDR_W = EEP_ADDR_W,
    parameter int OFF_W  = EEP_OFF_W,
    parameter int DATA_W = EEP_DATA_W,
    parameter int PROT_W = EEP_PROT_W
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   ld_en,
    input  logic [ADDR_W-1:0]                      ld_addr,
    input  logic                                   wr_en,
    input  logic [DATA_W-1:0]                      wr_data,
    input  logic                                   rd_en,
    input  logic                                   commit,
    input  logic                                   wp,
    input  logic [DATA_W-1:0]                      arr_rdata,
    output logic [ADDR_W-1:0]                      cur_addr,
    output logic [DATA_W-1:0]                      rd_data,
    output logic [(1<<OFF_W)-1:0]                  arr_we,
    output logic [ADDR_W-OFF_W-1:0]                arr_page,
    output logic [(1<<OFF_W)*DATA_W-1:0]           arr_wdata
);
    localparam int SLOTS  = 1 << OFF_W;
    localparam int PAGE_W = ADDR_W - OFF_W;

    eep_op_e                   op;
    logic [SLOTS-1:0]          eff_valid;
    logic [SLOTS*DATA_W-1:0]   eff_data;

    assign op = pick_op(ld_en, wr_en, rd_en);

    eep_addr_ctr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .ld_addr (ld_addr),
        .addr_q  (cur_addr)
    );

    eep_page_buf #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .off       (cur_addr[OFF_W-1:0]),
        .wr_data   (wr_data),
        .commit    (commit),
        .eff_valid (eff_valid),
        .eff_data  (eff_data)
    );

    eep_commit_gate #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .PROT_W(PROT_W)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .commit    (commit),
        .wp        (wp),
        .page      (cur_addr[ADDR_W-1:OFF_W]),
        .eff_valid (eff_valid),
        .eff_data  (eff_data),
        .arr_we    (arr_we),
        .arr_page  (arr_page),
        .arr_wdata (arr_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst)                rd_data <= '0;
        else if (op == OP_READ) rd_data <= arr_rdata;
    end

    a_r5_capture: assert property (@(posedge clk) disable iff (rst)
        op == OP_READ |=> rd_data == $past(arr_rdata));

    a_r5_rd_hold: assert property (@(posedge clk) disable iff (rst)
        op != OP_READ |=> $stable(rd_data));

    a_r8_joins_commit: assert property (@(posedge clk) disable iff (rst)
        (commit && op == OP_WRITE && !(wp && &cur_addr[ADDR_W-1 -: PROT_W]))
            |-> arr_we[cur_addr[OFF_W-1:0]]);

    logic unused_pw;
    assign unused_pw = (PAGE_W > 0);

endmodule

// File: tb/tb_eep_waddr_pbuf.sv
`timescale 1ns/1ps
module tb_eep_waddr_pbuf;

    logic         clk = 1'b0;
    logic         rst;
    logic         ld_en, wr_en, rd_en, commit, wp;
    logic [12:0]  ld_addr;
    logic [7:0]   wr_data;
    logic [7:0]   arr_rdata;
    logic [12:0]  cur_addr;
    logic [7:0]   rd_data;
    logic [31:0]  arr_we;
    logic [7:0]   arr_page;
    logic [255:0] arr_wdata;

    always #2.5 clk = ~clk;

    eep_waddr_pbuf dut (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .commit(commit),
        .wp(wp), .arr_rdata(arr_rdata), .cur_addr(cur_addr), .rd_data(rd_data),
        .arr_we(arr_we), .arr_page(arr_page), .arr_wdata(arr_wdata)
    );

    int total = 0;
    int fails = 0;
    bit done  = 0;

    function automatic logic [7:0] seed_byte(input int a);
        return 8'((a * 7) ^ (a >> 5) ^ 8'h5A);
    endfunction

    // backing array driven only by the DUT's write ports
    logic [7:0] bk [int];
    int         bk_ver = 0;

    function automatic logic [7:0] bk_read(input int a);
        if (bk.exists(a)) return bk[a];
        return seed_byte(a);
    endfunction

    always @(posedge clk) begin
        if (!rst && arr_we != 0) begin
            for (int i = 0; i < 32; i++)
                if (arr_we[i]) bk[(int'(arr_page) << 5) | i] = arr_wdata[i*8 +: 8];
            bk_ver++;
        end
    end

    always @(cur_addr or bk_ver) arr_rdata = bk_read(int'(cur_addr));

    // behavioural model
    int         m_addr = 0;
    logic [7:0] m_rd   = 0;
    bit         m_valid [32];
    logic [7:0] m_data  [32];
    logic [7:0] m_mem   [int];

    function automatic logic [7:0] m_read(input int a);
        if (m_mem.exists(a)) return m_mem[a];
        return seed_byte(a);
    endfunction

    task automatic chk(input string req, input string what, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input string req, input bit ld, input int la, input bit wr,
                        input logic [7:0] wd, input bit rd, input bit cm, input bit w);
        int         off;
        bit         wr_e, rd_e, prot;
        bit         ev [32];
        logic [7:0] ed [32];
        logic [31:0] exp_we;
        logic [255:0] mask;
        logic [255:0] exp_wd;
        @(negedge clk);
        ld_en = ld; ld_addr = 13'(la); wr_en = wr; wr_data = wd;
        rd_en = rd; commit = cm; wp = w;
        off  = m_addr & 31;
        wr_e = wr && !ld;
        rd_e = rd && !ld && !wr;
        for (int i = 0; i < 32; i++) begin ev[i] = m_valid[i]; ed[i] = m_data[i]; end
        if (wr_e) begin ev[off] = 1; ed[off] = wd; end
        prot   = w && (m_addr >= 'h1800);
        exp_we = '0;
        mask   = '0;
        exp_wd = '0;
        for (int i = 0; i < 32; i++)
            if (cm && !prot && ev[i]) begin
                exp_we[i] = 1'b1;
                mask[i*8 +: 8] = 8'hFF;
                exp_wd[i*8 +: 8] = ed[i];
            end
        #1;
        chk(req, "arr_we", 256'(arr_we), 256'(exp_we));
        if (exp_we != 0) begin
            chk(req, "arr_page", 256'(arr_page), 256'(m_addr >> 5));
            chk(req, "arr_wdata", arr_wdata & mask, exp_wd);
        end
        @(posedge clk);
        if (rd_e) m_rd = m_read(m_addr);
        for (int i = 0; i < 32; i++)
            if (exp_we[i]) m_mem[((m_addr >> 5) << 5) | i] = ed[i];
        if (cm || ld || rd_e) begin
            for (int i = 0; i < 32; i++) m_valid[i] = 0;
        end else if (wr_e) begin
            m_valid[off] = 1; m_data[off] = wd;
        end
        if (ld)        m_addr = la & 'h1FFF;
        else if (wr_e) m_addr = (m_addr & 'h1FE0) | ((off + 1) & 31);
        else if (rd_e) m_addr = (m_addr + 1) & 'h1FFF;
        #1;
        chk(req, "cur_addr", 256'(cur_addr), 256'(m_addr));
        chk(req, "rd_data", 256'(rd_data), 256'(m_rd));
    endtask

    task automatic idle(input string req);
        step(req, 0, 0, 0, 8'h00, 0, 0, 0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) begin m_valid[i] = 0; m_data[i] = 0; end
        rst = 1; ld_en = 0; ld_addr = 0; wr_en = 0; wr_data = 0;
        rd_en = 0; commit = 0; wp = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        chk("R1", "cur_addr", 256'(cur_addr), 256'(0));
        chk("R1", "rd_data", 256'(rd_data), 256'(0));
        chk("R1", "arr_we", 256'(arr_we), 256'(0));
        step("R1", 0, 0, 0, 0, 0, 1, 0);  // commit on empty buffer writes nothing

        // R2/R3/R7 partial page write
        step("R2", 1, 'h0123, 0, 0, 0, 0, 0);
        step("R3", 0, 0, 1, 8'hA1, 0, 0, 0);
        step("R3", 0, 0, 1, 8'hA2, 0, 0, 0);
        step("R3", 0, 0, 1, 8'hA3, 0, 0, 0);
        step("R7", 0, 0, 0, 0, 0, 1, 0);
        step("R6", 0, 0, 0, 0, 0, 0, 0);

        // R5 random read, then continue without load (R6)
        step("R2", 1, 'h0122, 0, 0, 0, 0, 0);
        for (int k = 0; k < 4; k++) step("R5", 0, 0, 0, 0, 1, 0, 0);
        idle("R6");
        step("R6", 0, 0, 0, 0, 1, 0, 0);

        // R3/R4 wrap within page and overwrite
        step("R2", 1, 'h005E, 0, 0, 0, 0, 0);
        for (int k = 0; k < 34; k++) step("R4", 0, 0, 1, 8'(8'h40 + k), 0, 0, 0);
        step("R4", 0, 0, 0, 0, 0, 1, 0);
        step("R4", 1, 'h005E, 0, 0, 0, 0, 0);
        for (int k = 0; k < 4; k++) step("R4", 0, 0, 0, 0, 1, 0, 0);
        step("R3", 1, 'h0040, 0, 0, 0, 0, 0);
        step("R3", 0, 0, 0, 0, 1, 0, 0);

        // R5 full rollover
        step("R2", 1, 'h1FFE, 0, 0, 0, 0, 0);
        for (int k = 0; k < 3; k++) step("R5", 0, 0, 0, 0, 1, 0, 0);

        // R9 protected top quarter
        step("R2", 1, 'h1810, 0, 0, 0, 0, 1);
        step("R9", 0, 0, 1, 8'hEE, 0, 0, 1);
        step("R9", 0, 0, 1, 8'hEF, 0, 0, 1);
        step("R9", 0, 0, 0, 0, 0, 1, 1);
        step("R9", 1, 'h1810, 0, 0, 0, 0, 1);
        step("R9", 0, 0, 0, 0, 1, 0, 1);
        step("R9", 0, 0, 0, 0, 1, 0, 1);
        step("R9", 1, 'h17F0, 0, 0, 0, 0, 1);
        step("R9", 0, 0, 1, 8'h3C, 0, 1, 1);
        step("R9", 1, 'h1FF0, 0, 0, 0, 0, 0);
        step("R9", 0, 0, 1, 8'h3D, 0, 0, 1);
        step("R9", 0, 0, 0, 0, 0, 1, 0);
        step("R9", 1, 'h1FF0, 0, 0, 0, 0, 0);
        step("R9", 0, 0, 0, 0, 1, 0, 0);

        // R8 write together with commit, R2/R5 strobe collisions
        step("R2", 1, 'h0200, 0, 0, 0, 0, 0);
        step("R8", 0, 0, 1, 8'h11, 0, 0, 0);
        step("R8", 0, 0, 1, 8'h22, 0, 1, 0);
        step("R8", 0, 0, 0, 0, 0, 1, 0);
        step("R2", 1, 'h0300, 1, 8'h99, 1, 0, 0);
        step("R5", 0, 0, 1, 8'h77, 1, 0, 0);
        step("R5", 0, 0, 0, 0, 1, 0, 0);
        step("R5", 0, 0, 0, 0, 0, 1, 0);
        step("R8", 1, 'h0200, 0, 0, 0, 0, 0);
        step("R8", 0, 0, 0, 0, 1, 0, 0);
        step("R8", 0, 0, 0, 0, 1, 0, 0);

        // mixed traffic
        for (int k = 0; k < 1500; k++) begin
            int  r;
            int  la;
            bit  ld, wr, rd, cm, w;
            r  = $urandom;
            ld = (r % 16) == 0;
            wr = ((r >> 4) % 2) == 0;
            rd = ((r >> 5) % 4) == 0;
            cm = ((r >> 7) % 8) == 0;
            w  = ((r >> 10) % 2) == 0;
            case ((r >> 11) % 4)
                0: la = 'h1FE0 + ((r >> 13) % 32);
                1: la = 'h17E0 + ((r >> 13) % 64);
                2: la = ((r >> 13) % 8) << 5 | 28;
                default: la = (r >> 13) & 'h1FFF;
            endcase
            step("R7", ld, la, wr, 8'(r >> 20), rd, cm, w);
        end

        done = 1;
        summary();
        $finish;
    end

endmodule